// File: doc/BRIEF.md
# Banked GPIO Controller with Edge-Triggered Interrupts

This block controls sixteen general-purpose pins, split into two banks of eight, through a byte-wide register bus. The bus has an address, write data, a write enable and a combinational read-data return. For each pin, one configuration register sets whether the block drives the pin, whether it drives it push-pull or open-drain, the pull resistor choice and the driven value. These settings appear on per-pin output ports. Pad electrics are handled outside the block. A second per-pin register returns the pin's synchronised level and holds its interrupt edge mode.

Each incoming pin passes through a two-flop synchroniser. An edge detector compares the synchronised level with its value one clock earlier. When the edge matches the pin's mode, a sticky pending bit is set. Software clears pending bits by writing ones to them. An active-state mask decides which pending bits drive the single interrupt output. A second, sleep-state mask is held for system use and does not affect the interrupt output. The register bus has no handshake: a write is taken on every clock edge where the write enable is high, and read data follows the address in the same cycle. No data stream crosses this block, so there is no back-pressure.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0x00, every pin is an input (pin_oe all zero), all outputs are zero and irq is low.
- R2: Pin p's configuration register is at 0x2B+p for p in 0..7 and at 0x3B+(p-8) for p in 8..15. Bits 5:0 are stored and read back, and bits 7:6 read 0. Bit 5 drives pin_oe[p], bit 4 drives pin_od[p], bit 3 drives pin_pull_en[p], bits 2:1 drive pin_pull_sel[2p+1:2p] (00 weak-2k down, 01 2k up, 10 50k down, 11 50k up) and bit 0 drives pin_out[p].
- R3: Pin p's input register is at 0x33+p for p in 0..7 and at 0x43+(p-8) for p in 8..15. Bit 0 returns the synchronised level: a pin change set up before clock edge k becomes visible after edge k+1. Bits 2:1 hold the edge mode and can be read and written. All other bits read 0 and ignore writes.
- R4: Edge mode 00 disables detection, 01 detects falling edges, 10 rising edges and 11 both. A detected edge on pin p sets pending bit p%8 of its bank one clock after the edge reaches the synchronised level, so the bit can be read after edge k+2.
- R5: The pending registers are at 0x0B (pins 0-7) and 0x0C (pins 8-15), with bit n for pin bank*8+n. Writing a 1 clears a bit, writing a 0 leaves it unchanged, and pending bits are cleared in no other way.
- R6: If an edge sets a pending bit in the same cycle that a write of 1 clears it, the bit ends up set.
- R7: The active-state masks are at 0x19 and 0x1A, and a 1 masks the pin. A masked pin still sets its pending bit, but that bit does not raise irq.
- R8: The sleep-state masks are at 0x1B and 0x1C. They store and read back all eight bits and have no effect on irq.
- R9: irq is high in every cycle in which some pending bit has its active-state mask bit at 0, and low otherwise.
- R10: Every address outside the listed registers reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write enable, one write per high cycle |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven value per pin |
| pin_oe | output | 16 | Drive enable per pin (1 = output) |
| pin_od | output | 16 | Open-drain select per pin |
| pin_pull_en | output | 16 | Pull enable per pin |
| pin_pull_sel | output | 32 | Two-bit pull choice per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Several patterns drive the edge path, and each one isolates a different part of the behaviour:
- Rising and falling steps on pins with each of the four modes show whether the mode decode is right.
- A single step on a bank-1 pin shows that bank-1 events reach bank-1 bits and not bank-0 bits.
- Steps on a masked pin show that masking gates only irq and not the pending state.
- A clearing write placed in the very cycle the edge lands, and then one cycle later, separates a design where the set wins from one where the clear wins.

A cycle model in the bench tracks every register, pin output and irq. The bench then sweeps all 256 addresses, which exposes decode aliasing and any unmapped writes that leak into a register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NBANK = 2;

  localparam int ADDR_PEND0  = 8'h0B;
  localparam int ADDR_MASK0  = 8'h19;
  localparam int ADDR_SLEEP0 = 8'h1B;
  localparam int ADDR_OCTL0  = 8'h2B;
  localparam int ADDR_ICTL0  = 8'h33;
  localparam int CTL_STRIDE  = 16;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       dir;
    logic       od;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       val;
  } out_cfg_t;

  function automatic logic [7:0] octl_addr(int b, int i);
    return 8'(ADDR_OCTL0 + b * CTL_STRIDE + i);
  endfunction

  function automatic logic [7:0] ictl_addr(int b, int i);
    return 8'(ADDR_ICTL0 + b * CTL_STRIDE + i);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '0;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det import gpio_pkg::*; #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   lvl,
  input  logic [2*W-1:0] mode_flat,
  output logic [W-1:0]   hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    logic chg;
    logic h;
    assign chg = lvl[i] ^ prev[i];
    always_comb begin
      unique case (edge_mode_e'(mode_flat[2*i +: 2]))
        EDGE_OFF:  h = 1'b0;
        EDGE_FALL: h = chg & ~lvl[i];
        EDGE_RISE: h = chg & lvl[i];
        EDGE_BOTH: h = chg;
        default:   h = 1'b0;
      endcase
    end
    assign hit[i] = h;
  end

  // R4: a detection only ever follows a real change of the synchronised level
  assert_edge_real_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> ((hit & ~(lvl ^ $past(lvl))) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] wdata,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic         sleep_we,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic [W-1:0] sleep,
  output logic         req
);
  logic [W-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '0;
      sleep <= '0;
    end else begin
      pend <= (pend & ~clr_bits) | hit;
      if (mask_we)  mask  <= wdata;
      if (sleep_we) sleep <= wdata;
    end
  end

  assign req = |(pend & ~mask);

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend & $past(wdata & ~hit)) == '0));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |=> (($past(pend) & ~$past(clr_bits) & ~pend) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl import gpio_pkg::*; #(
  parameter int BANK_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                reg_addr,
  input  logic [7:0]                reg_wdata,
  input  logic                      reg_we,
  output logic [7:0]                reg_rdata,
  input  logic [NBANK*BANK_W-1:0]   pin_in,
  output logic [NBANK*BANK_W-1:0]   pin_out,
  output logic [NBANK*BANK_W-1:0]   pin_oe,
  output logic [NBANK*BANK_W-1:0]   pin_od,
  output logic [NBANK*BANK_W-1:0]   pin_pull_en,
  output logic [2*NBANK*BANK_W-1:0] pin_pull_sel,
  output logic                      irq
);
  localparam int NPIN  = NBANK * BANK_W;
  localparam int CFG_W = $bits(out_cfg_t);

  logic [NPIN-1:0]       lvl;
  logic [NPIN-1:0]       hit;
  logic [2*NPIN-1:0]     mode_flat;
  logic [CFG_W*NPIN-1:0] cfg_flat;
  logic [NPIN-1:0]       pend_all, mask_all, sleep_all;
  logic [NBANK-1:0]      bank_req;
  logic                  addr_hit;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
  );

  gpio_edge_det #(.W(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .mode_flat(mode_flat), .hit(hit)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int B = p / BANK_W;
    localparam int I = p % BANK_W;
    out_cfg_t   cfg_q;
    logic [1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q  <= '0;
        mode_q <= '0;
      end else if (reg_we) begin
        if (reg_addr == octl_addr(B, I)) cfg_q  <= out_cfg_t'(reg_wdata[CFG_W-1:0]);
        if (reg_addr == ictl_addr(B, I)) mode_q <= reg_wdata[2:1];
      end
    end

    assign cfg_flat[CFG_W*p +: CFG_W] = cfg_q;
    assign mode_flat[2*p +: 2]        = mode_q;
    assign pin_oe[p]                  = cfg_q.dir;
    assign pin_od[p]                  = cfg_q.od;
    assign pin_pull_en[p]             = cfg_q.pull_en;
    assign pin_pull_sel[2*p +: 2]     = cfg_q.pull_sel;
    assign pin_out[p]                 = cfg_q.val;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gpio_irq_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit[b*BANK_W +: BANK_W]),
      .wdata    (reg_wdata[BANK_W-1:0]),
      .clr_we   (reg_we && (reg_addr == 8'(ADDR_PEND0 + b))),
      .mask_we  (reg_we && (reg_addr == 8'(ADDR_MASK0 + b))),
      .sleep_we (reg_we && (reg_addr == 8'(ADDR_SLEEP0 + b))),
      .pend     (pend_all[b*BANK_W +: BANK_W]),
      .mask     (mask_all[b*BANK_W +: BANK_W]),
      .sleep    (sleep_all[b*BANK_W +: BANK_W]),
      .req      (bank_req[b])
    );
  end

  assign irq = |bank_req;

  always_comb begin
    reg_rdata = '0;
    addr_hit  = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr == 8'(ADDR_PEND0 + b)) begin
        reg_rdata = 8'(pend_all[b*BANK_W +: BANK_W]);
        addr_hit  = 1'b1;
      end
      if (reg_addr == 8'(ADDR_MASK0 + b)) begin
        reg_rdata = 8'(mask_all[b*BANK_W +: BANK_W]);
        addr_hit  = 1'b1;
      end
      if (reg_addr == 8'(ADDR_SLEEP0 + b)) begin
        reg_rdata = 8'(sleep_all[b*BANK_W +: BANK_W]);
        addr_hit  = 1'b1;
      end
      for (int i = 0; i < BANK_W; i++) begin
        if (reg_addr == octl_addr(b, i)) begin
          reg_rdata = 8'(cfg_flat[CFG_W*(b*BANK_W+i) +: CFG_W]);
          addr_hit  = 1'b1;
        end
        if (reg_addr == ictl_addr(b, i)) begin
          reg_rdata = {5'b0, mode_flat[2*(b*BANK_W+i) +: 2], lvl[b*BANK_W+i]};
          addr_hit  = 1'b1;
        end
      end
    end
  end

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (reg_rdata == 8'h00));

  assert_all_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_all) |-> !irq);
endmodule

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, pin_od, pin_pull_en;
  logic [31:0] pin_pull_sel;
  logic        irq;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_od(pin_od), .pin_pull_en(pin_pull_en),
    .pin_pull_sel(pin_pull_sel), .irq(irq)
  );

  // reference model state
  int          m_oc [16];
  int          m_md [16];
  logic [15:0] m_s1, m_s2, m_pv, m_pend, m_mask, m_slp;

  function automatic int oaddr(int p);
    return (p < 8) ? 8'h2B + p : 8'h3B + p - 8;
  endfunction

  function automatic int iaddr(int p);
    return oaddr(p) + 8;
  endfunction

  function automatic logic [7:0] model_rd(int a);
    if (a == 8'h0B) return m_pend[7:0];
    if (a == 8'h0C) return m_pend[15:8];
    if (a == 8'h19) return m_mask[7:0];
    if (a == 8'h1A) return m_mask[15:8];
    if (a == 8'h1B) return m_slp[7:0];
    if (a == 8'h1C) return m_slp[15:8];
    for (int p = 0; p < 16; p++) begin
      if (a == oaddr(p)) return 8'(m_oc[p]);
      if (a == iaddr(p)) return 8'((m_md[p] << 1) | int'(m_s2[p]));
    end
    return 8'h00;
  endfunction

  function automatic string tag_of(int a);
    if (a == 8'h0B || a == 8'h0C) return "R5";
    if (a == 8'h19 || a == 8'h1A) return "R7";
    if (a == 8'h1B || a == 8'h1C) return "R8";
    if (a >= 8'h2B && a <= 8'h32) return "R2";
    if (a >= 8'h3B && a <= 8'h42) return "R2";
    if (a >= 8'h33 && a <= 8'h3A) return "R3";
    if (a >= 8'h43 && a <= 8'h4A) return "R3";
    return "R10";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [15:0] hv, cv;
    if (!rst_n) begin
      for (int p = 0; p < 16; p++) begin m_oc[p] = 0; m_md[p] = 0; end
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_pend = '0; m_mask = '0; m_slp = '0;
    end else begin
      hv = '0;
      cv = '0;
      for (int p = 0; p < 16; p++) begin
        if (m_s2[p] != m_pv[p]) begin
          if (m_md[p] == 3) hv[p] = 1'b1;
          if (m_md[p] == 2 && m_s2[p]) hv[p] = 1'b1;
          if (m_md[p] == 1 && !m_s2[p]) hv[p] = 1'b1;
        end
      end
      if (reg_we) begin
        case (int'(reg_addr))
          8'h0B: cv[7:0] = reg_wdata;
          8'h0C: cv[15:8] = reg_wdata;
          8'h19: m_mask[7:0] = reg_wdata;
          8'h1A: m_mask[15:8] = reg_wdata;
          8'h1B: m_slp[7:0] = reg_wdata;
          8'h1C: m_slp[15:8] = reg_wdata;
          default: ;
        endcase
        for (int p = 0; p < 16; p++) begin
          if (int'(reg_addr) == oaddr(p)) m_oc[p] = int'(reg_wdata) & 8'h3F;
          if (int'(reg_addr) == iaddr(p)) m_md[p] = int'(reg_wdata[2:1]);
        end
      end
      m_pend = (m_pend & ~cv) | hv;
      m_pv = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] e_oe, e_od, e_pe, e_out;
    logic [31:0] e_ps;
    #2;
    for (int p = 0; p < 16; p++) begin
      e_oe[p]        = m_oc[p][5];
      e_od[p]        = m_oc[p][4];
      e_pe[p]        = m_oc[p][3];
      e_ps[2*p +: 2] = 2'(m_oc[p] >> 1);
      e_out[p]       = m_oc[p][0];
    end
    chk("R9", 32'(irq), 32'(|(m_pend & ~m_mask)));
    chk("R2", 32'(pin_oe), 32'(e_oe));
    chk("R2", 32'(pin_od), 32'(e_od));
    chk("R2", 32'(pin_pull_en), 32'(e_pe));
    chk("R2", pin_pull_sel, e_ps);
    chk("R2", 32'(pin_out), 32'(e_out));
    chk(tag_of(int'(reg_addr)), 32'(reg_rdata), 32'(model_rd(int'(reg_addr))));
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_addr = 8'(a); reg_wdata = 8'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic expect_rd(int a, int exp, string tag);
    @(negedge clk);
    reg_addr = 8'(a);
    #4;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(8'h0B, 0, "R1");
    expect_rd(8'h1A, 0, "R1");
    expect_rd(8'h2B, 0, "R1");
    expect_rd(8'h43, 0, "R1");
    chk("R1", 32'(irq), 0);
    chk("R1", 32'(pin_oe), 0);

    // R2 configuration fields
    wr(8'h2E, 8'h3F);
    expect_rd(8'h2E, 8'h3F, "R2");
    chk("R2", 32'(pin_oe[3]), 1);
    chk("R2", 32'(pin_od[3]), 1);
    chk("R2", 32'(pin_pull_en[3]), 1);
    chk("R2", 32'(pin_pull_sel[7:6]), 3);
    chk("R2", 32'(pin_out[3]), 1);
    wr(8'h3D, 8'hE5);
    expect_rd(8'h3D, 8'h25, "R2");
    chk("R2", 32'(pin_oe[10]), 1);
    chk("R2", 32'(pin_od[10]), 0);
    chk("R2", 32'(pin_pull_sel[21:20]), 2);

    // R3 level latency and writable field
    @(negedge clk); pin_in[5] = 1'b1;
    expect_rd(8'h38, 8'h00, "R3");
    expect_rd(8'h38, 8'h01, "R3");
    wr(8'h3A, 8'hF9);
    expect_rd(8'h3A, 8'h00, "R3");
    wr(8'h3A, 8'h06);
    expect_rd(8'h3A, 8'h06, "R3");
    wr(8'h3A, 8'h00);

    // R4 modes: pin0 fall, pin1 rise, pin2 both, pin3 off
    wr(8'h33, 8'h02); wr(8'h34, 8'h04); wr(8'h35, 8'h06); wr(8'h36, 8'h00);
    @(negedge clk); pin_in[3:0] = 4'hF;
    repeat (4) @(negedge clk);
    expect_rd(8'h0B, 8'h06, "R4");
    chk("R9", 32'(irq), 1);

    // R5 write-one-to-clear
    wr(8'h0B, 8'h00);
    expect_rd(8'h0B, 8'h06, "R5");
    wr(8'h0B, 8'h02);
    expect_rd(8'h0B, 8'h04, "R5");
    wr(8'h0B, 8'hFF);
    expect_rd(8'h0B, 8'h00, "R5");
    chk("R9", 32'(irq), 0);

    @(negedge clk); pin_in[3:0] = 4'h0;
    repeat (4) @(negedge clk);
    expect_rd(8'h0B, 8'h05, "R4");

    // bank 1 rising edge on pin 9
    wr(8'h44, 8'h04);
    @(negedge clk); pin_in[9] = 1'b1;
    repeat (4) @(negedge clk);
    expect_rd(8'h0C, 8'h02, "R4");

    // R7 active mask
    wr(8'h19, 8'hFF);
    expect_rd(8'h19, 8'hFF, "R7");
    chk("R7", 32'(irq), 1);
    wr(8'h1A, 8'h02);
    chk("R7", 32'(irq), 0);
    expect_rd(8'h0C, 8'h02, "R7");
    wr(8'h0B, 8'hFF);
    @(negedge clk); pin_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    pin_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    expect_rd(8'h0B, 8'h01, "R7");
    chk("R7", 32'(irq), 0);

    // R8 sleep mask is storage only
    wr(8'h1B, 8'hA5);
    expect_rd(8'h1B, 8'hA5, "R8");
    wr(8'h19, 8'h00);
    wr(8'h1C, 8'hFF);
    chk("R8", 32'(irq), 1);
    expect_rd(8'h1C, 8'hFF, "R8");

    // R9 combined request
    wr(8'h1A, 8'h00);
    chk("R9", 32'(irq), 1);
    wr(8'h0B, 8'hFF);
    wr(8'h0C, 8'hFF);
    chk("R9", 32'(irq), 0);

    // R6 edge and clear in the same cycle: set wins
    wr(8'h37, 8'h06);
    @(negedge clk); pin_in[4] = 1'b1;
    @(negedge clk);
    wr(8'h0B, 8'h10);
    expect_rd(8'h0B, 8'h10, "R6");
    wr(8'h0B, 8'h10);
    expect_rd(8'h0B, 8'h00, "R6");
    @(negedge clk); pin_in[4] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr(8'h0B, 8'h10);
    expect_rd(8'h0B, 8'h00, "R6");

    // R10 unmapped addresses
    wr(8'h00, 8'hFF); wr(8'h0A, 8'hFF); wr(8'h0D, 8'hFF); wr(8'h1D, 8'hFF);
    wr(8'h2A, 8'hFF); wr(8'h4B, 8'hFF); wr(8'hFF, 8'hFF);
    expect_rd(8'h00, 0, "R10");
    expect_rd(8'h0D, 0, "R10");
    expect_rd(8'h2A, 0, "R10");
    expect_rd(8'h4B, 0, "R10");
    expect_rd(8'hFF, 0, "R10");
    for (int a = 0; a < 256; a++) expect_rd(a, int'(model_rd(a)), tag_of(a));

    repeat (2) @(negedge clk);
    summary();
  end
endmodule